// File: doc/BRIEF.md
# Serial Converter Port Controller

This block is the digital half of a multi-channel serial sampling converter, seen from the device side. It runs on a fast system clock. The host's serial clock, chip select and serial address line are oversampled through a two-flop synchronizer, and edges are detected in the system clock domain. During each host transaction the block collects a 4-bit channel address on the first four rising serial-clock edges. It shifts the previously held 12-bit result out, MSB first, one bit per falling edge. When the transaction ends it starts a conversion. A conversion timer stands in for the analog core. When the timer runs out, the word on `convData` (supplied by an external stub for the channel on `convChan`) is captured into the output buffer, and the end-of-conversion flag rises.

Chip select works in two ways. The host can hold it low for good, in which case each fresh result shows its first bit on the data line as end-of-conversion rises. The host can also raise it between transactions, in which case the first bit is on the line as chip select falls. Raising chip select disables the data driver at once. A debounced high level freezes the interface. A debounced low level then resets it, and an interrupted conversion is dropped without touching the held result. The address value 1110 selects a low-power state, in which no conversion starts. The block also enters that state at power-on.

Top module: `sadc_port_top`

## Requirements
- R1: After reset, `pwrDown` is 1, `eocOut` is 1, and the held result is all zeros, so `sdo` reads 0 once chip select is active.
- R2: The channel address is taken on the first four rising serial-clock edges of a transaction, first bit as address bit 3. It appears on `convChan` and does not change while `eocOut` is low.
- R3: While `csNIn` is high, `sdoOe` is 0 in the same cycle, without waiting for synchronization or debounce.
- R4: Once `csNIn` has been high for `DEB_CYC` synchronized cycles, serial-clock edges have no effect: no power-down change, no conversion start and no address change.
- R5: When chip select was high between transactions, the MSB of the held result is already on `sdo` when `csNIn` falls.
- R6: A transaction is 12 serial-clock periods. The held word is sent MSB first, the first bit before the first falling edge and each later falling edge moving to the next bit. A transaction that starts no conversion leaves the same held word ready for the next one.
- R7: On the 12th falling edge, unless power-down is in force, `convStart` pulses for one cycle and `eocOut` goes low. `sdo` is 0 while `eocOut` is low.
- R8: `eocOut` stays low for exactly `CONV_CYC` system cycles. It then rises with the MSB of the captured `convData` already on `sdo`.
- R9: Address 1110 sets `pwrDown` on the 4th falling edge (not on the 3rd). No conversion follows that transaction, and the held result is kept.
- R10: From power-on, `pwrDown` stays 1 until the end of a transaction whose address is not 1110. It is still 1 after that transaction's 4th falling edge. A conversion then starts at once.
- R11: `csNIn` low for `DEB_CYC` synchronized cycles resets the interface and aborts a running conversion, and `eocOut` returns to 1. After the serial clock has stayed low for `IDLE_CYC` cycles, the next transaction sends the result held before the abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| ioClkIn | input | 1 | Host serial clock (asynchronous) |
| csNIn | input | 1 | Host chip select, active low |
| addrIn | input | 1 | Host serial address input |
| convData | input | 12 | Result word from the conversion stub |
| convChan | output | 4 | Channel address of the current or last transaction |
| convStart | output | 1 | One-cycle pulse when a conversion begins |
| eocOut | output | 1 | End-of-conversion flag, low while converting |
| pwrDown | output | 1 | Low-power state indicator |
| sdo | output | 1 | Serial result data bit |
| sdoOe | output | 1 | Output enable for the serial data driver |

## Verification
Transactions are run with chip select held low across a chain of addresses. The chain covers power-down exit, two normal conversions, power-down entry, a repeated power-down address and the exit again, so each read-back word shows whether a result was captured, kept or replaced. Chip-select pulses are then applied in three places: between transactions to test the early first bit, during an idle period with serial-clock activity to test that edges are frozen, and during a running conversion to tell a kept buffer from a wrongly captured one. Result words differ per channel and some have MSB 1, so a forced-zero data line is never mistaken for a first bit.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftBit;  // synchronized serial address bit
    logic shiftIn;   // take shiftBit into the address register
    logic advance;   // move the output shifter one bit
    logic reload;    // copy the held result into the output shifter
    logic capture;   // conversion done: store convData
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_XFER = 2'd1,
    ST_CONV = 2'd2
  } ctrlState_t;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RST_VAL;
      syncOut <= RST_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 4,
  parameter int DEB_CYC  = 4,
  parameter int IDLE_CYC = 6,
  parameter int CONV_CYC = 120,
  parameter logic [ADDR_W-1:0] PD_CODE = ADDR_W'(14)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioS,
  input  logic              csS,
  input  logic              dinS,
  input  logic [ADDR_W-1:0] addrWord,
  output dpStrobe_t         strb,
  output logic              eocOut,
  output logic              pwrDown,
  output logic              convStart
);

  localparam int RC_W = $clog2(ADDR_W + 1);
  localparam int FC_W = $clog2(DATA_W + 1);
  localparam int DB_W = $clog2(DEB_CYC + 1);
  localparam int ID_W = $clog2(IDLE_CYC + 1);
  localparam int CV_W = $clog2(CONV_CYC + 1);

  ctrlState_t      state;
  logic            ioDly;
  logic            riseEv, fallEv;
  logic            armed;        // 1: interface frozen, waiting for debounced low
  logic [DB_W-1:0] debCnt;
  logic            debHit, resetEv;
  logic [RC_W-1:0] riseCnt;
  logic [FC_W-1:0] fallCnt;
  logic [ID_W-1:0] idleCnt;
  logic [CV_W-1:0] convCnt;
  logic            xferOk, lastFall, doCap;

  always_comb begin
    riseEv   = ioS & ~ioDly;
    fallEv   = ~ioS & ioDly;
    debHit   = (csS ^ armed) && (debCnt == DB_W'(DEB_CYC - 1));
    resetEv  = debHit & armed;
    xferOk   = (state == ST_XFER) & ~armed;
    lastFall = (fallCnt == FC_W'(DATA_W - 1));
    doCap    = (state == ST_CONV) && (convCnt == CV_W'(CONV_CYC - 1)) && !resetEv;

    strb          = '0;
    strb.shiftBit = dinS;
    strb.shiftIn  = xferOk & riseEv & (riseCnt < RC_W'(ADDR_W));
    strb.advance  = xferOk & fallEv & ~lastFall;
    strb.reload   = csS | (xferOk & fallEv & lastFall);
    strb.capture  = doCap;
  end

  // chip-select debounce: one counter, direction chosen by the armed flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b1;
      debCnt <= '0;
      ioDly  <= 1'b0;
    end else begin
      ioDly <= ioS;
      if (csS ^ armed) begin
        if (debHit) begin
          debCnt <= '0;
          armed  <= ~armed;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end else begin
        debCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_WAIT;
      riseCnt   <= '0;
      fallCnt   <= '0;
      idleCnt   <= '0;
      convCnt   <= '0;
      eocOut    <= 1'b1;
      pwrDown   <= 1'b1;
      convStart <= 1'b0;
    end else begin
      convStart <= 1'b0;
      if (resetEv) begin
        state   <= ST_WAIT;
        riseCnt <= '0;
        fallCnt <= '0;
        idleCnt <= '0;
        convCnt <= '0;
        eocOut  <= 1'b1;
      end else begin
        case (state)
          ST_WAIT: begin
            if (armed || ioS) begin
              idleCnt <= '0;
            end else if (idleCnt == ID_W'(IDLE_CYC - 1)) begin
              idleCnt <= '0;
              state   <= ST_XFER;
            end else begin
              idleCnt <= idleCnt + 1'b1;
            end
          end
          ST_XFER: begin
            if (!armed) begin
              if (strb.shiftIn) riseCnt <= riseCnt + 1'b1;
              if (fallEv) begin
                if (fallCnt == FC_W'(ADDR_W - 1) && addrWord == PD_CODE)
                  pwrDown <= 1'b1;
                if (lastFall) begin
                  fallCnt <= '0;
                  riseCnt <= '0;
                  if (addrWord != PD_CODE) begin
                    pwrDown   <= 1'b0;
                    convStart <= 1'b1;
                    eocOut    <= 1'b0;
                    convCnt   <= '0;
                    state     <= ST_CONV;
                  end
                end else begin
                  fallCnt <= fallCnt + 1'b1;
                end
              end
            end
          end
          ST_CONV: begin
            if (doCap) begin
              eocOut <= 1'b1;
              state  <= ST_XFER;
            end else begin
              convCnt <= convCnt + 1'b1;
            end
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end

endmodule

// File: rtl/sadc_dpath.sv
module sadc_dpath
  import sadc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] convData,
  input  logic              eocIn,
  input  logic              csNIn,
  output logic [ADDR_W-1:0] addrWord,
  output logic              sdo,
  output logic              sdoOe
);

  logic [DATA_W-1:0] bufReg;
  logic [DATA_W-1:0] outSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg   <= '0;
      outSh    <= '0;
      addrWord <= '0;
    end else begin
      if (strb.capture) begin
        bufReg <= convData;
        outSh  <= convData;
      end else if (strb.reload) begin
        outSh <= bufReg;
      end else if (strb.advance) begin
        outSh <= {outSh[DATA_W-2:0], 1'b0};
      end
      if (strb.shiftIn)
        addrWord <= {addrWord[ADDR_W-2:0], strb.shiftBit};
    end
  end

  // data forced low while a conversion runs; driver follows raw chip select
  assign sdo   = eocIn ? outSh[DATA_W-1] : 1'b0;
  assign sdoOe = ~csNIn;

endmodule

// File: rtl/sadc_port_top.sv
module sadc_port_top
  import sadc_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int ADDR_W   = 4,
  parameter int DEB_CYC  = 4,
  parameter int IDLE_CYC = 6,
  parameter int CONV_CYC = 120
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioClkIn,
  input  logic              csNIn,
  input  logic              addrIn,
  input  logic [DATA_W-1:0] convData,
  output logic [ADDR_W-1:0] convChan,
  output logic              convStart,
  output logic              eocOut,
  output logic              pwrDown,
  output logic              sdo,
  output logic              sdoOe
);

  logic [2:0]  syncQ;
  dpStrobe_t   dpStrb;
  logic        capPulse;

  sadc_sync #(.W(3), .RST_VAL(3'b010)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({addrIn, csNIn, ioClkIn}),
    .syncOut(syncQ)
  );

  sadc_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEB_CYC(DEB_CYC),
    .IDLE_CYC(IDLE_CYC), .CONV_CYC(CONV_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ioS      (syncQ[0]),
    .csS      (syncQ[1]),
    .dinS     (syncQ[2]),
    .addrWord (convChan),
    .strb     (dpStrb),
    .eocOut   (eocOut),
    .pwrDown  (pwrDown),
    .convStart(convStart)
  );

  sadc_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (dpStrb),
    .convData(convData),
    .eocIn   (eocOut),
    .csNIn   (csNIn),
    .addrWord(convChan),
    .sdo     (sdo),
    .sdoOe   (sdoOe)
  );

  assign capPulse = dpStrb.capture;

endmodule

// File: rtl/sadc_port_chk.sv
module sadc_port_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              csNIn,
  input logic [DATA_W-1:0] convData,
  input logic [ADDR_W-1:0] convChan,
  input logic              eocOut,
  input logic              pwrDown,
  input logic              sdo,
  input logic              sdoOe,
  input logic              capPulse
);

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csNIn |-> !sdoOe);  // R3

  AST_ZERO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !eocOut |-> !sdo);  // R7

  AST_MSB_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    capPulse |=> (eocOut && sdo == $past(convData[DATA_W-1])));  // R8

  AST_SLEEP_NO_CONVERT: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> eocOut);  // R9

  AST_CHAN_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!eocOut && $past(!eocOut)) |-> $stable(convChan));  // R2

endmodule

bind sadc_port_top sadc_port_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_sadc_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csNIn   (csNIn),
  .convData(convData),
  .convChan(convChan),
  .eocOut  (eocOut),
  .pwrDown (pwrDown),
  .sdo     (sdo),
  .sdoOe   (sdoOe),
  .capPulse(capPulse)
);

// File: tb/test_sadc_port_top.sv
module test_sadc_port_top;

  localparam int DW = 12, AW = 4, DEB = 4, IDLE = 6, CONV = 120, HALF = 6;

  typedef struct packed {
    logic [3:0]  addr;
    logic [11:0] expRead;
    logic        pdAfter;
    logic        conv;
  } vec_t;

  // chained host transactions, chip select low throughout
  localparam vec_t VEC [6] = '{
    '{4'h3, 12'h000, 1'b0, 1'b1},
    '{4'h7, 12'h3C9, 1'b0, 1'b1},
    '{4'hE, 12'h789, 1'b1, 1'b0},
    '{4'hE, 12'h789, 1'b1, 1'b0},
    '{4'h0, 12'h789, 1'b0, 1'b1},
    '{4'hA, 12'h0F9, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0, ioClk = 1'b0, csN = 1'b1, din = 1'b0;
  logic [DW-1:0] convData;
  logic [AW-1:0] convChan;
  logic convStart, eoc, pd, sdo, sdoOe;

  int checks = 0, fails = 0, startCnt = 0, lowRun = 0, lastRun = 0, wd = 0;
  bit pdAt3, pdAt4;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] fw(input logic [AW-1:0] c);
    return {c, ~c, 4'h9};
  endfunction

  assign convData = fw(convChan);

  sadc_port_top #(.DEB_CYC(DEB), .IDLE_CYC(IDLE), .CONV_CYC(CONV)) i_sadc_port_top (
    .clk(clk), .rstN(rstN), .ioClkIn(ioClk), .csNIn(csN), .addrIn(din),
    .convData(convData), .convChan(convChan), .convStart(convStart),
    .eocOut(eoc), .pwrDown(pd), .sdo(sdo), .sdoOe(sdoOe)
  );

  always @(negedge clk) begin
    if (convStart) startCnt++;
    if (!eoc) lowRun++;
    else if (lowRun != 0) begin lastRun = lowRun; lowRun = 0; end
  end

  always @(negedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitEoc();
    int g = 0;
    while (!eoc && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic hostCycle(input logic [3:0] addr, output logic [DW-1:0] rd);
    for (int i = 0; i < DW; i++) begin
      din = (i < AW) ? addr[AW-1-i] : 1'b0;
      waitClk(HALF);
      rd[DW-1-i] = sdo;
      if (i == 3) pdAt3 = pd;
      if (i == 4) pdAt4 = pd;
      ioClk = 1'b1;
      waitClk(HALF);
      ioClk = 1'b0;
    end
    waitClk(4);
  endtask

  task automatic pulseIdle(input logic [3:0] pattern);
    for (int i = 0; i < DW; i++) begin
      din = (i < AW) ? pattern[AW-1-i] : 1'b0;
      waitClk(HALF); ioClk = 1'b1;
      waitClk(HALF); ioClk = 1'b0;
    end
    waitClk(4);
  endtask

  initial begin
    logic [DW-1:0] rd, nw;
    bit pdBefore;
    int sc;
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);
    // R1 reset state
    chk(pd == 1'b1, "R1 pwrDown after reset", pd, 1);
    chk(eoc == 1'b1, "R1 eoc after reset", eoc, 1);
    chk(sdoOe == 1'b0, "R3 driver off with csN high", sdoOe, 0);
    csN = 1'b0;
    waitClk(DEB + IDLE + 8);
    chk(sdo == 1'b0, "R1 held word zero", sdo, 0);

    foreach (VEC[k]) begin
      pdBefore = pd;
      sc = startCnt;
      hostCycle(VEC[k].addr, rd);
      chk(rd == VEC[k].expRead, "R6 word read MSB first", rd, VEC[k].expRead);
      chk(pd == VEC[k].pdAfter, "R9 R10 pwrDown after cycle", pd, VEC[k].pdAfter);
      if (k == 0) chk(pdAt4 == 1'b1, "R10 still asleep after 4th fall", pdAt4, 1);
      if (VEC[k].addr == 4'hE && !pdBefore) begin
        chk(pdAt3 == 1'b0, "R9 not asleep after 3rd fall", pdAt3, 0);
        chk(pdAt4 == 1'b1, "R9 asleep after 4th fall", pdAt4, 1);
      end
      if (VEC[k].conv) begin
        chk(convChan == VEC[k].addr, "R2 channel address", convChan, VEC[k].addr);
        chk(startCnt == sc + 1, "R7 one start pulse", startCnt, sc + 1);
        chk(eoc == 1'b0 && sdo == 1'b0, "R7 busy with data low", {eoc, sdo}, 0);
        waitEoc();
        nw = fw(VEC[k].addr);
        chk(sdo == nw[DW-1], "R8 first bit at eoc rise", sdo, nw[DW-1]);
        waitClk(2);
        chk(lastRun == CONV, "R8 conversion length", lastRun, CONV);
      end else begin
        waitClk(CONV + 5);
        chk(eoc == 1'b1 && startCnt == sc, "R9 no conversion in sleep", startCnt, sc);
      end
    end

    // R4: frozen interface ignores serial clock, R3 immediate release
    sc = startCnt;
    csN = 1'b1;
    #1 chk(sdoOe == 1'b0, "R3 driver off at once", sdoOe, 0);
    waitClk(DEB + 6);
    pulseIdle(4'hE);
    chk(pd == 1'b0, "R4 no sleep from frozen edges", pd, 0);
    chk(eoc == 1'b1 && startCnt == sc, "R4 no start from frozen edges", startCnt, sc);
    chk(convChan == 4'hA, "R4 address unchanged", convChan, 4'hA);

    // R5: first bit on chip-select fall (held word 0xA59)
    @(negedge clk);
    csN = 1'b0;
    #1 chk(sdoOe == 1'b1 && sdo == 1'b1, "R5 MSB on cs fall", {sdoOe, sdo}, 3);
    waitClk(DEB + IDLE + 8);

    // R11: abort a running conversion, held word kept
    hostCycle(4'hC, rd);
    chk(rd == 12'hA59, "R6 word after cs re-entry", rd, 12'hA59);
    chk(eoc == 1'b0, "R7 conversion running", eoc, 0);
    csN = 1'b1;
    waitClk(DEB + 4);
    csN = 1'b0;
    waitClk(DEB + 4);
    chk(eoc == 1'b1, "R11 conversion aborted", eoc, 1);
    chk(sdo == 1'b1, "R11 held MSB kept", sdo, 1);
    waitClk(IDLE + 6);
    hostCycle(4'hC, rd);
    chk(rd == 12'hA59, "R11 previous word shifted out", rd, 12'hA59);
    waitEoc();
    chk(sdo == 1'b1, "R8 new MSB at eoc rise", sdo, 1);
    waitClk(2);

    // R5 again with the fresh word 0xC39
    csN = 1'b1;
    waitClk(DEB + 4);
    csN = 1'b0;
    #1 chk(sdo == 1'b1 && sdoOe == 1'b1, "R5 MSB on cs fall after conversion", {sdoOe, sdo}, 3);
    waitClk(DEB + IDLE + 8);
    hostCycle(4'h2, rd);
    chk(rd == 12'hC39, "R5 R6 word after cs between conversions", rd, 12'hC39);
    waitEoc();
    waitClk(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule